// File: doc/BRIEF.md
# Timestamped Run-Length Cluster Packer

This block turns a stream of 16-bit samples into compressed records for a sample memory. A sample is offered on every pulse of `tick`. A free-running tick count provides the time base. A sample that equals the previous one is not stored. Changed samples are grouped into clusters of eight words: one timestamp word followed by seven event slots. Each slot belongs to one consecutive tick, starting at the timestamp. A cluster is written when it closes, as a burst of eight words to consecutive memory addresses. The address splits into a row number in the upper bits and a word-within-row number in the lower bits.

If the input stays quiet, a cluster is still forced at a fixed tick interval, so that a reader can always work out the time across timestamp rollover. A `stop` request ends the capture. The open cluster is flushed, and the address that follows the last written word is reported as the stop position.

Two state machines do the work. The collector has three states. `CL_IDLE` means no cluster is open. A changed or forced tick moves it to `CL_OPEN`. An unchanged tick, or the tick that fills the seventh slot, moves it back to `CL_IDLE`. A stop moves it from either state to `CL_HALT`, which is final. The emitter also has three states. `EM_IDLE` moves to `EM_SEND` when a closed cluster arrives. `EM_SEND` sends eight words. After the eighth word it goes back to `EM_IDLE`, or reloads at once if another cluster is waiting, or goes to `EM_HALT` after the final cluster. `EM_IDLE` goes straight to `EM_HALT` when a stop finds no open cluster.

Ticks must be at least eight clocks apart.

Top module: `rl_cluster_packer`

## Requirements
- R1: A closed cluster is written as eight words on eight consecutive clocks, to consecutive addresses. Word 0 is the timestamp, words 1 to 7 are the event slots, and the first word always lands on an address whose low three bits are zero.
- R2: The timestamp is the number of ticks accepted since reset, modulo 2^16, so the first tick is 0. The first event of a cluster is the sample of the tick the cluster was opened on. Event k holds the sample of tick timestamp+k.
- R3: A tick whose sample equals the sample of the previous tick stores no event. If a cluster is open, that tick closes it.
- R4: When no cluster is open and the input has not changed, a cluster is still opened on the tick that lies FORCE_TICKS ticks after the last tick that opened a cluster (65536 by default). Its first event is the current sample.
- R5: After reset the previous-sample reference is 0, and the first accepted tick always opens a cluster, with timestamp 0.
- R6: Event slots that a cluster did not fill are written with the value of its last stored event.
- R7: The write address is {row, word}: the upper ROW_BITS (15 by default) select the row, and the lower COL_BITS (9) select the word within the row. It advances by one per word and wraps from the last row back to row 0. `round` rises on the first such wrap and stays high until reset.
- R8: A `stop` pulse waits until no cluster is being written. It then closes any open cluster, which is written as a normal cluster. After that `stop_done` goes high and `stop_pos` gives the address that follows the last written word. `stop_pos` reads 0 before that. Later ticks and stops cause no writes.
- R9: A changed tick with no open cluster opens one. The tick that stores the seventh event closes the cluster at once. The next changed tick then opens a new cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One sample period; samples `sample` |
| sample | input | WORD_W | Input pin levels |
| stop | input | 1 | Request to end capture (pulse) |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ROW_BITS+COL_BITS | Memory word address {row, word} |
| wr_data | output | WORD_W | Memory write word |
| round | output | 1 | Row address has wrapped at least once |
| stop_done | output | 1 | Capture ended, final cluster written |
| stop_pos | output | ROW_BITS+COL_BITS | Address after the last written word, 0 until `stop_done` |

## Verification
The bench drives long runs of changes so that a full cluster closes and the very next changed tick must open a fresh one. An off-by-one in the slot count would lose or duplicate an event there. It holds the input quiet across several forcing intervals and checks each forced timestamp. A wrong counter start or reset would shift every forced cluster, including the first one at timestamp 0. Isolated single changes check the padding, where a design that padded with stale slots or zeros would show up at once. The bench also writes past the last row to catch an address that fails to wrap or a `round` flag that stays low. It stops with a cluster still open and checks that this cluster is flushed, that the reported position is the next free address, and that later ticks write nothing.

// File: rtl/rlcp_pkg.sv
package rlcp_pkg;

    // Collector: is a cluster being assembled?
    typedef enum logic [1:0] {
        CL_IDLE,
        CL_OPEN,
        CL_HALT
    } coll_state_e;

    // Emitter: burst of one cluster to memory
    typedef enum logic [1:0] {
        EM_IDLE,
        EM_SEND,
        EM_HALT
    } emit_state_e;

endpackage

// File: rtl/rlcp_collector.sv
module rlcp_collector
    import rlcp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int EVENTS      = 7,
    parameter int FORCE_TICKS = 65536
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic [WORD_W-1:0]            sample,
    input  logic                         stop,
    input  logic                         emit_idle,
    output logic                         close_v,
    output logic                         close_last,
    output logic [(EVENTS+1)*WORD_W-1:0] close_words,
    output logic                         stop_empty
);

    localparam int CNT_W   = $clog2(EVENTS + 1);
    localparam int SINCE_W = $clog2(FORCE_TICKS);
    localparam logic [SINCE_W-1:0] FORCE_LAST = SINCE_W'(FORCE_TICKS - 1);
    localparam logic [CNT_W-1:0]   FULL_IDX   = CNT_W'(EVENTS - 1);

    coll_state_e state_q, state_n;

    logic [WORD_W-1:0]  ts_q, ts_n;
    logic [WORD_W-1:0]  prev_q, prev_n;
    logic [WORD_W-1:0]  cl_ts_q, cl_ts_n;
    logic [SINCE_W-1:0] since_q, since_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [WORD_W-1:0]  ev_q [EVENTS];
    logic [WORD_W-1:0]  ev_n [EVENTS];
    logic               stop_pend_q;
    logic               close_v_q, close_last_q, stop_empty_q;
    logic [(EVENTS+1)*WORD_W-1:0] close_words_q, snap;

    logic stop_go, step, chg, force_hit;
    logic do_close, last_n, empty_n;

    assign stop_go   = stop_pend_q && emit_idle && !close_v_q && (state_q != CL_HALT);
    assign step      = tick && (state_q != CL_HALT) && !stop_go;
    assign chg       = (sample != prev_q);
    assign force_hit = (since_q == FORCE_LAST);

    // Next state and next cluster contents
    always_comb begin
        state_n  = state_q;
        cl_ts_n  = cl_ts_q;
        since_n  = since_q;
        cnt_n    = cnt_q;
        ev_n     = ev_q;
        do_close = 1'b0;
        last_n   = 1'b0;
        empty_n  = 1'b0;
        if (stop_go) begin
            if (state_q == CL_OPEN) begin
                do_close = 1'b1;
                last_n   = 1'b1;
            end else begin
                empty_n  = 1'b1;
            end
            state_n = CL_HALT;
        end else if (step) begin
            unique case (state_q)
                CL_IDLE: begin
                    if (chg || force_hit) begin
                        state_n  = CL_OPEN;
                        cl_ts_n  = ts_q;
                        ev_n[0]  = sample;
                        cnt_n    = CNT_W'(1);
                        since_n  = '0;
                    end else begin
                        since_n  = since_q + 1'b1;
                    end
                end
                CL_OPEN: begin
                    since_n = since_q + 1'b1;
                    if (chg) begin
                        ev_n[cnt_q] = sample;
                        cnt_n       = cnt_q + 1'b1;
                        if (cnt_q == FULL_IDX) begin
                            do_close = 1'b1;
                            state_n  = CL_IDLE;
                        end
                    end else begin
                        do_close = 1'b1;
                        state_n  = CL_IDLE;
                    end
                end
                CL_HALT: ;
                default: ;
            endcase
        end
    end

    assign ts_n   = step ? ts_q + 1'b1 : ts_q;
    assign prev_n = step ? sample : prev_q;

    // Snapshot of the closing cluster: unused slots repeat the last sample
    assign snap[WORD_W-1:0] = cl_ts_q;
    for (genvar k = 0; k < EVENTS; k++) begin : g_slot
        assign snap[(k+1)*WORD_W +: WORD_W] = (CNT_W'(k) < cnt_n) ? ev_n[k] : prev_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CL_IDLE;
        else        state_q <= state_n;
    end

    // Data and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q          <= '0;
            prev_q        <= '0;
            cl_ts_q       <= '0;
            since_q       <= FORCE_LAST;
            cnt_q         <= '0;
            for (int i = 0; i < EVENTS; i++) ev_q[i] <= '0;
            stop_pend_q   <= 1'b0;
            close_v_q     <= 1'b0;
            close_last_q  <= 1'b0;
            stop_empty_q  <= 1'b0;
            close_words_q <= '0;
        end else begin
            ts_q          <= ts_n;
            prev_q        <= prev_n;
            cl_ts_q       <= cl_ts_n;
            since_q       <= since_n;
            cnt_q         <= cnt_n;
            ev_q          <= ev_n;
            stop_pend_q   <= stop_go ? 1'b0 : (stop_pend_q | stop);
            close_v_q     <= do_close;
            close_last_q  <= last_n;
            stop_empty_q  <= empty_n;
            if (do_close) close_words_q <= snap;
        end
    end

    assign close_v     = close_v_q;
    assign close_last  = close_last_q;
    assign close_words = close_words_q;
    assign stop_empty  = stop_empty_q;

    a_r4_force_window: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= FORCE_LAST)
        else $error("R4: tick distance since last opening exceeds forcing interval");

    a_r3_quiet_no_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CL_IDLE && step && !chg) |=> !close_v_q)
        else $error("R3: unchanged tick with no open cluster closed something");

    a_r9_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CL_OPEN) |-> (cnt_q >= CNT_W'(1) && cnt_q <= FULL_IDX))
        else $error("R9: open cluster holds an impossible event count");

    a_r8_halt_final: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CL_HALT) |=> (state_q == CL_HALT && !close_v_q))
        else $error("R8: collector left halt or closed a cluster after stop");

endmodule

// File: rtl/rlcp_emitter.sv
module rlcp_emitter
    import rlcp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EVENTS = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         close_v,
    input  logic                         close_last,
    input  logic [(EVENTS+1)*WORD_W-1:0] close_words,
    input  logic                         stop_empty,
    input  logic [$clog2(EVENTS+1)-1:0]  addr_lo,
    output logic                         wr_en,
    output logic [WORD_W-1:0]            wr_data,
    output logic                         emit_idle,
    output logic                         halted
);

    localparam int WORDS  = EVENTS + 1;
    localparam int BEAT_W = $clog2(WORDS);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(WORDS - 1);

    emit_state_e state_q, state_n;
    logic [BEAT_W-1:0]       beat_q, beat_n;
    logic [WORDS*WORD_W-1:0] buf_q, buf_n;
    logic                    fin_q, fin_n;

    always_comb begin
        state_n = state_q;
        beat_n  = beat_q;
        buf_n   = buf_q;
        fin_n   = fin_q;
        unique case (state_q)
            EM_IDLE: begin
                if (close_v) begin
                    state_n = EM_SEND;
                    beat_n  = '0;
                    buf_n   = close_words;
                    fin_n   = close_last;
                end else if (stop_empty) begin
                    state_n = EM_HALT;
                end
            end
            EM_SEND: begin
                if (beat_q == BEAT_LAST) begin
                    if (fin_q) begin
                        state_n = EM_HALT;
                    end else if (close_v) begin
                        beat_n = '0;
                        buf_n  = close_words;
                        fin_n  = close_last;
                    end else begin
                        state_n = EM_IDLE;
                    end
                end else begin
                    beat_n = beat_q + 1'b1;
                    buf_n  = buf_q >> WORD_W;
                end
            end
            EM_HALT: ;
            default: state_n = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EM_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            buf_q  <= '0;
            fin_q  <= 1'b0;
        end else begin
            beat_q <= beat_n;
            buf_q  <= buf_n;
            fin_q  <= fin_n;
        end
    end

    assign wr_en     = (state_q == EM_SEND);
    assign wr_data   = buf_q[WORD_W-1:0];
    assign emit_idle = (state_q == EM_IDLE);
    assign halted    = (state_q == EM_HALT);

    a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        close_v |-> (state_q == EM_IDLE || (state_q == EM_SEND && beat_q == BEAT_LAST)))
        else $error("R1: cluster arrived while a burst was still in progress");

    a_r1_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_SEND && beat_q == '0) |-> (addr_lo == '0))
        else $error("R1: cluster does not start on an aligned address");

    a_r1_burst_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_SEND && beat_q != BEAT_LAST) |=> (state_q == EM_SEND))
        else $error("R1: burst broken before its last word");

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_HALT) |=> (state_q == EM_HALT))
        else $error("R8: emitter left halt");

endmodule

// File: rtl/rlcp_addr.sv
module rlcp_addr #(
    parameter int ROW_BITS = 15,
    parameter int COL_BITS = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         inc,
    output logic [ROW_BITS+COL_BITS-1:0] addr,
    output logic                         round
);

    localparam int ADDR_W = ROW_BITS + COL_BITS;

    logic [ADDR_W-1:0] ptr_q;
    logic              round_q;
    logic              at_end;

    assign at_end = (ptr_q == {ADDR_W{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            round_q <= 1'b0;
        end else if (inc) begin
            ptr_q <= ptr_q + 1'b1;
            if (at_end) round_q <= 1'b1;
        end
    end

    assign addr  = ptr_q;
    assign round = round_q;

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (addr == $past(addr) + 1'b1))
        else $error("R7: address did not advance by one per word");

    a_r7_round_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && addr == {ADDR_W{1'b1}}) |=> (round && addr == '0))
        else $error("R7: wrap of the last row not flagged");

    a_r7_round_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        round |=> round)
        else $error("R7: round flag dropped");

endmodule

// File: rtl/rl_cluster_packer.sv
module rl_cluster_packer #(
    parameter int WORD_W      = 16,
    parameter int EVENTS      = 7,
    parameter int ROW_BITS    = 15,
    parameter int COL_BITS    = 9,
    parameter int FORCE_TICKS = 65536
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic [WORD_W-1:0]            sample,
    input  logic                         stop,
    output logic                         wr_en,
    output logic [ROW_BITS+COL_BITS-1:0] wr_addr,
    output logic [WORD_W-1:0]            wr_data,
    output logic                         round,
    output logic                         stop_done,
    output logic [ROW_BITS+COL_BITS-1:0] stop_pos
);

    localparam int WORDS  = EVENTS + 1;
    localparam int BEAT_W = $clog2(WORDS);

    logic                    close_v, close_last, stop_empty, emit_idle;
    logic [WORDS*WORD_W-1:0] close_words;

    rlcp_collector #(
        .WORD_W      (WORD_W),
        .EVENTS      (EVENTS),
        .FORCE_TICKS (FORCE_TICKS)
    ) u_coll (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .sample      (sample),
        .stop        (stop),
        .emit_idle   (emit_idle),
        .close_v     (close_v),
        .close_last  (close_last),
        .close_words (close_words),
        .stop_empty  (stop_empty)
    );

    rlcp_emitter #(
        .WORD_W (WORD_W),
        .EVENTS (EVENTS)
    ) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .close_v     (close_v),
        .close_last  (close_last),
        .close_words (close_words),
        .stop_empty  (stop_empty),
        .addr_lo     (wr_addr[BEAT_W-1:0]),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .emit_idle   (emit_idle),
        .halted      (stop_done)
    );

    rlcp_addr #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_en),
        .addr  (wr_addr),
        .round (round)
    );

    assign stop_pos = stop_done ? wr_addr : '0;

    a_r8_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> (!wr_en && stop_pos == wr_addr))
        else $error("R8: write or moving position after stop");

endmodule

// File: tb/rl_cluster_packer_test.sv
module rl_cluster_packer_test;

    localparam int WW  = 16;
    localparam int EV  = 7;
    localparam int RB  = 2;
    localparam int CB  = 9;
    localparam int AW  = RB + CB;
    localparam int FT  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [WW-1:0] sample = '0;
    logic          stop = 1'b0;
    logic          wr_en, round, stop_done;
    logic [AW-1:0] wr_addr, stop_pos;
    logic [WW-1:0] wr_data;

    rl_cluster_packer #(
        .WORD_W(WW), .EVENTS(EV), .ROW_BITS(RB), .COL_BITS(CB), .FORCE_TICKS(FT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sample(sample), .stop(stop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .round(round),
        .stop_done(stop_done), .stop_pos(stop_pos)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference
    int    r_ts, r_prev, r_since, r_cts, r_wptr;
    bit    r_open, r_halt, r_round;
    int    r_ev[$];
    int    q_data[$];
    int    q_addr[$];
    string q_tag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void push_word(input int d, input string tag);
        q_data.push_back(d & 16'hFFFF);
        q_addr.push_back(r_wptr);
        q_tag.push_back(tag);
        r_wptr = (r_wptr + 1) % (1 << AW);
        if (r_wptr == 0) r_round = 1'b1;
    endfunction

    function automatic void push_cluster(input int pad);
        push_word(r_cts, "R2");
        for (int k = 0; k < EV; k++) begin
            if (k < r_ev.size()) push_word(r_ev[k], "R2");
            else                 push_word(pad, "R6");
        end
        r_ev.delete();
        r_open = 1'b0;
    endfunction

    function automatic void ref_tick(input int v);
        bit chg;
        chg = (v != r_prev);
        if (r_open) begin
            r_since++;
            if (chg) begin
                r_ev.push_back(v);
                if (r_ev.size() == EV) push_cluster(v);
            end else begin
                push_cluster(r_prev);
            end
        end else if (chg || r_since == FT - 1) begin
            r_open  = 1'b1;
            r_cts   = r_ts;
            r_ev.delete();
            r_ev.push_back(v);
            r_since = 0;
        end else begin
            r_since++;
        end
        r_prev = v;
        r_ts   = (r_ts + 1) & 16'hFFFF;
    endfunction

    // compare every write against the reference stream
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R8", "write with nothing expected", int'(wr_data), -1);
            end else begin
                int    d, a;
                string t;
                d = q_data.pop_front();
                a = q_addr.pop_front();
                t = q_tag.pop_front();
                check(int'(wr_data) == d, t, "word data", int'(wr_data), d);
                check(int'(wr_addr) == a, "R1", "word address", int'(wr_addr), a);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic do_tick(input int v);
        @(negedge clk);
        sample = WW'(v);
        tick   = 1'b1;
        if (!r_halt) ref_tick(v & 16'hFFFF);
        @(negedge clk);
        tick = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic drain();
        repeat (14) @(negedge clk);
        check(q_data.size() == 0, "R1", "words still owed", q_data.size(), 0);
    endtask

    initial begin
        r_ts = 0; r_prev = 0; r_since = FT - 1; r_cts = 0; r_wptr = 0;
        r_open = 0; r_halt = 0; r_round = 0;

        repeat (4) @(negedge clk);
        check(wr_en == 1'b0, "R1", "write during reset", int'(wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stop_done == 1'b0, "R8", "stop_done after reset", int'(stop_done), 0);
        check(stop_pos == '0, "R8", "stop_pos after reset", int'(stop_pos), 0);
        check(round == 1'b0, "R7", "round after reset", int'(round), 0);

        // R5: first tick with an unchanged zero still opens at timestamp 0
        do_tick(0);
        do_tick(0);
        drain();

        // R9: nine consecutive changes: one full cluster, then a new one
        for (int i = 1; i <= 9; i++) do_tick(i * 3);
        do_tick(27);
        drain();

        // R3 / R6: isolated changes with gaps, padded slots
        do_tick(5); do_tick(5); do_tick(5); do_tick(77); do_tick(77);
        do_tick(78); do_tick(200); do_tick(200);
        drain();

        // R4: quiet input across several forcing intervals
        for (int i = 0; i < 70; i++) do_tick(200);
        drain();
        check(round == 1'b0, "R7", "round before any wrap", int'(round), 0);

        // R7: enough short clusters to run past the last row
        for (int i = 0; i < 900; i++) begin
            if (i % 3 == 2) do_tick(r_prev);
            else            do_tick((i * 37 + 5) & 16'hFFFF);
        end
        drain();
        check(int'(round) == int'(r_round), "R7", "round after wrap", int'(round), int'(r_round));
        check(round == 1'b1, "R7", "wrap reached", int'(round), 1);

        // R8: stop with a cluster open
        do_tick(4321);
        @(negedge clk);
        stop = 1'b1;
        if (r_open) push_cluster(r_prev);
        r_halt = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        drain();
        check(stop_done == 1'b1, "R8", "stop_done after flush", int'(stop_done), 1);
        check(int'(stop_pos) == r_wptr, "R8", "stop position", int'(stop_pos), r_wptr);

        // R8: ticks after stop write nothing
        do_tick(11); do_tick(12); do_tick(12);
        drain();
        check(int'(stop_pos) == r_wptr, "R8", "stop position held", int'(stop_pos), r_wptr);
        check(wr_en == 1'b0, "R8", "write strobe after stop", int'(wr_en), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule